// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

The sequencer collects three reset requests: an asynchronous power-on input and two shared open-drain lines, one for hard reset and one for soft reset. It drives the two lines in a fixed order. Each line is split into a sensed input and a drive enable. When the enable is 1, the line is pulled low. When it is 0, the line is released. A hard reset always pulls soft reset low as well. Each pulse lasts a parameterised number of clock cycles, and soft reset is never released before hard reset. The block watches the lines for requests from outside only while it is idle and both lines read high again. Because of this it never mistakes its own drive for an external request.

When power-on reset is released, the block captures five configuration strap bits into mode outputs and holds them until the next power-on reset. A three-bit status register records which sources caused reset. Software clears the flags through a plain write port that always accepts a write, so it has no valid/ready handshake and no back-pressure. The block carries no streaming data.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_n` is low, `hard_drive` and `soft_drive` are both 1, `rst_status` is 3'b001 and every mode output is 0. This takes effect without waiting for a clock edge.
- R2: On the second rising clock edge after `por_n` rises, the straps are captured. The captured bits are `mode_dbg` (1 = debug entry), `mode_host_en` (1 = host port on), `mode_boot` (00 = external memory, 01 = host port) and `mode_slave` (1 = slave). Later strap changes have no effect on the mode outputs.
- R3: After power-on release, `hard_drive` stays 1 for `HARD_CYC` more cycles after that second edge. `soft_drive` stays 1 for a further `SOFT_CYC` cycles.
- R4: A sensed line counts as a request only when it stays low for at least two consecutive clock cycles. The request passes through a two-flop synchroniser, and the drive rises on the fourth rising edge after the line falls. A low lasting one cycle is ignored.
- R5: A detected external hard request drives `hard_drive` for `HARD_CYC` cycles and `soft_drive` for `HARD_CYC+SOFT_CYC` cycles. `hard_drive` is never 1 while `soft_drive` is 0.
- R6: A detected external soft request drives `soft_drive` for `SOFT_CYC` cycles and leaves `hard_drive` at 0.
- R7: Low levels on the sensed lines are ignored while either drive is 1. They are also ignored after release until both lines have read high for two sampled cycles. An ignored low starts no sequence and sets no flag.
- R8: When hard and soft requests appear in the same cycle, only the hard sequence runs and only the hard flag is set.
- R9: `rst_status` has bit 0 = power-on, bit 1 = external hard and bit 2 = external soft. A detection sets its bit. A `csr_wr` with `csr_wdata` bit = 1 clears that bit. A set in the same cycle as a clear wins. Bit 0 is set only by power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| hard_pin_n | input | 1 | Sensed level of hard reset line |
| soft_pin_n | input | 1 | Sensed level of soft reset line |
| hard_drive | output | 1 | Pull hard reset line low |
| soft_drive | output | 1 | Pull soft reset line low |
| strap_dbg | input | 1 | Debug-entry strap |
| strap_host_en | input | 1 | Host port enable strap |
| strap_boot | input | 2 | Boot source strap |
| strap_slave | input | 1 | Master/slave strap |
| mode_dbg | output | 1 | Captured debug-entry mode |
| mode_host_en | output | 1 | Captured host port enable |
| mode_boot | output | 2 | Captured boot source |
| mode_slave | output | 1 | Captured master/slave mode |
| csr_wr | input | 1 | Status write strobe |
| csr_wdata | input | 3 | Write-one-to-clear mask |
| rst_status | output | 3 | Reset cause flags |

## Verification
The bench drives the sensed lines in four ways:
- Pulls of one cycle separate glitch rejection from true detection.
- Pulls of two to six cycles confirm that a detection happens exactly at the filter threshold.
- Hard alone, soft alone and both together distinguish the hard-over-soft priority from the plain soft sequence, by the measured pulse lengths and the flags.
- Pulls that overlap the block's own drive, or outlast it, show whether the busy and release-wait blocking holds.

A status clear timed into the detection cycle shows that the set takes priority.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HARD = 2'd1,
    ST_SOFT = 2'd2,
    ST_WAIT = 2'd3
  } rsc_state_e;

  localparam int STAT_W    = 3;
  localparam int STAT_POR  = 0;
  localparam int STAT_HARD = 1;
  localparam int STAT_SOFT = 2;

  typedef struct packed {
    logic       dbg;
    logic       host_en;
    logic [1:0] boot;
    logic       slave;
  } rsc_cfg_t;
endpackage

// File: rtl/rsc_pin_filter.sv
module rsc_pin_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic req,
  output logic quiet
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      hist_q <= sync_q[MSB];
    end
  end

  // two consecutive low samples form a request; two high samples mean idle line
  assign req   = ~sync_q[MSB] & ~hist_q;
  assign quiet =  sync_q[MSB] &  hist_q;
endmodule

// File: rtl/rsc_seq_fsm.sv
module rsc_seq_fsm
  import rsc_pkg::*;
#(
  parameter int HARD_CYC = 16,
  parameter int SOFT_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_done,
  input  logic hard_req,
  input  logic soft_req,
  input  logic hard_quiet,
  input  logic soft_quiet,
  output logic hard_drive,
  output logic soft_drive,
  output logic hard_det,
  output logic soft_det
);
  localparam int MAXC = (HARD_CYC > SOFT_CYC) ? HARD_CYC : SOFT_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] HARD_LOAD = CW'(HARD_CYC - 1);
  localparam logic [CW-1:0] SOFT_LOAD = CW'(SOFT_CYC - 1);

  rsc_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    hard_det = 1'b0;
    soft_det = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (hard_req) begin
          state_d  = ST_HARD;
          cnt_d    = HARD_LOAD;
          hard_det = 1'b1;
        end else if (soft_req) begin
          state_d  = ST_SOFT;
          cnt_d    = SOFT_LOAD;
          soft_det = 1'b1;
        end
      end
      ST_HARD: begin
        if (!por_done) begin
          cnt_d = HARD_LOAD;
        end else if (cnt_q == '0) begin
          state_d = ST_SOFT;
          cnt_d   = SOFT_LOAD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_SOFT: begin
        if (cnt_q == '0) state_d = ST_WAIT;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_WAIT: begin
        if (hard_quiet && soft_quiet) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HARD;
      cnt_q   <= HARD_LOAD;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign hard_drive = (state_q == ST_HARD);
  assign soft_drive = (state_q == ST_HARD) || (state_q == ST_SOFT);

  AST_HARD_HANDS_TO_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hard_drive) |-> soft_drive); // R5
  AST_SOFT_ENDS_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(soft_drive) |-> $past(cnt_q) == '0); // R6
  AST_HARD_WINS_TIE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && hard_req && soft_req) |=> hard_drive); // R8
endmodule

// File: rtl/rsc_status_reg.sv
module rsc_status_reg
  import rsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_done,
  input  logic              hard_det,
  input  logic              soft_det,
  input  logic              wr,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] stat
);
  localparam logic [STAT_W-1:0] POR_VAL = STAT_W'(1) << STAT_POR;

  logic [STAT_W-1:0] set_v, clr_v, stat_q;

  always_comb begin
    set_v            = '0;
    set_v[STAT_HARD] = hard_det;
    set_v[STAT_SOFT] = soft_det;
    clr_v            = wr ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         stat_q <= POR_VAL;
    else if (!por_done) stat_q <= POR_VAL;
    else                stat_q <= (stat_q & ~clr_v) | set_v;
  end

  assign stat = stat_q;

  AST_POR_FLAG_ONLY_AT_POR: assert property (@(posedge clk) disable iff (!rst_n)
    (por_done && $past(por_done) && !$past(stat_q[STAT_POR])) |-> !stat_q[STAT_POR]); // R9
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rsc_pkg::*;
#(
  parameter int HARD_CYC    = 16,
  parameter int SOFT_CYC    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              hard_pin_n,
  input  logic              soft_pin_n,
  output logic              hard_drive,
  output logic              soft_drive,
  input  logic              strap_dbg,
  input  logic              strap_host_en,
  input  logic [1:0]        strap_boot,
  input  logic              strap_slave,
  output logic              mode_dbg,
  output logic              mode_host_en,
  output logic [1:0]        mode_boot,
  output logic              mode_slave,
  input  logic              csr_wr,
  input  logic [STAT_W-1:0] csr_wdata,
  output logic [STAT_W-1:0] rst_status
);
  logic [1:0] por_q;
  logic       por_done, por_rel;
  logic       hard_req, soft_req, hard_quiet, soft_quiet;
  logic       hard_det, soft_det;
  rsc_cfg_t   cfg_q;

  // release synchroniser: assertion is immediate, release takes two edges
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) por_q <= 2'b00;
    else        por_q <= {por_q[0], 1'b1};
  end
  assign por_done = por_q[1];
  assign por_rel  = por_q[0] & ~por_q[1];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       cfg_q <= '0;
    else if (por_rel) cfg_q <= '{dbg: strap_dbg, host_en: strap_host_en,
                                 boot: strap_boot, slave: strap_slave};
  end
  assign mode_dbg     = cfg_q.dbg;
  assign mode_host_en = cfg_q.host_en;
  assign mode_boot    = cfg_q.boot;
  assign mode_slave   = cfg_q.slave;

  rsc_pin_filter #(.SYNC_STAGES(SYNC_STAGES)) u_hard_flt (
    .clk(clk), .rst_n(por_n), .pin_n(hard_pin_n), .req(hard_req), .quiet(hard_quiet)
  );
  rsc_pin_filter #(.SYNC_STAGES(SYNC_STAGES)) u_soft_flt (
    .clk(clk), .rst_n(por_n), .pin_n(soft_pin_n), .req(soft_req), .quiet(soft_quiet)
  );

  rsc_seq_fsm #(.HARD_CYC(HARD_CYC), .SOFT_CYC(SOFT_CYC)) u_fsm (
    .clk(clk), .rst_n(por_n), .por_done(por_done),
    .hard_req(hard_req), .soft_req(soft_req),
    .hard_quiet(hard_quiet), .soft_quiet(soft_quiet),
    .hard_drive(hard_drive), .soft_drive(soft_drive),
    .hard_det(hard_det), .soft_det(soft_det)
  );

  rsc_status_reg u_stat (
    .clk(clk), .rst_n(por_n), .por_done(por_done),
    .hard_det(hard_det), .soft_det(soft_det),
    .wr(csr_wr), .wdata(csr_wdata), .stat(rst_status)
  );

  AST_POR_HOLDS_HARD: assert property (@(posedge clk) disable iff (!por_n)
    !por_done |-> hard_drive); // R1
  AST_MODES_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
    (por_q[1] && $past(por_q[1])) |-> $stable(cfg_q)); // R2
  AST_DETECT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_status[STAT_HARD]) |-> $past(!hard_drive && !soft_drive)); // R7
endmodule

// File: tb/rst_seq_ctrl_tb_top.sv
module rst_seq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HC = 12;
  localparam int SC = 6;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic ext_hard = 1'b0, ext_soft = 1'b0;
  logic hard_pin_n, soft_pin_n, hard_drive, soft_drive;
  logic s_dbg = 0, s_host = 0, s_slave = 0;
  logic [1:0] s_boot = 0;
  logic m_dbg, m_host, m_slave;
  logic [1:0] m_boot;
  logic csr_wr = 0;
  logic [2:0] csr_wdata = 0;
  logic [2:0] rst_status;

  int n_tests = 0, n_fail = 0;
  int hc_cnt = 0, sc_cnt = 0, bad_cnt = 0;
  bit mon_en = 0;
  logic [2:0] exp_stat;

  always #(CLK_PERIOD/2) clk = ~clk;

  // open-drain lines: low when either side pulls
  assign hard_pin_n = ~(hard_drive | ext_hard);
  assign soft_pin_n = ~(soft_drive | ext_soft);

  rst_seq_ctrl #(.HARD_CYC(HC), .SOFT_CYC(SC)) dut_i (
    .clk(clk), .por_n(por_n), .hard_pin_n(hard_pin_n), .soft_pin_n(soft_pin_n),
    .hard_drive(hard_drive), .soft_drive(soft_drive),
    .strap_dbg(s_dbg), .strap_host_en(s_host), .strap_boot(s_boot), .strap_slave(s_slave),
    .mode_dbg(m_dbg), .mode_host_en(m_host), .mode_boot(m_boot), .mode_slave(m_slave),
    .csr_wr(csr_wr), .csr_wdata(csr_wdata), .rst_status(rst_status)
  );

  always @(negedge clk) begin
    if (mon_en) begin
      if (hard_drive) hc_cnt++;
      if (soft_drive) sc_cnt++;
      if (hard_drive && !soft_drive) bad_cnt++;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_hard(bit h, int len);
    return (h && len >= 2) ? HC : 0;
  endfunction
  function automatic int exp_soft(bit h, bit s, int len);
    if (len < 2) return 0;
    if (h) return HC + SC;
    return s ? SC : 0;
  endfunction
  function automatic logic [2:0] exp_set(bit h, bit s, int len);
    if (len < 2) return 3'b000;
    if (h) return 3'b010;
    return s ? 3'b100 : 3'b000;
  endfunction

  task automatic start_mon();
    hc_cnt = 0; sc_cnt = 0; bad_cnt = 0; mon_en = 1;
  endtask

  task automatic pulse(bit h, bit s, int len);
    @(negedge clk); #1;
    start_mon();
    ext_hard = h; ext_soft = s;
    repeat (len) @(negedge clk);
    #1; ext_hard = 0; ext_soft = 0;
    repeat (HC + SC + 20) @(negedge clk);
    mon_en = 0;
  endtask

  task automatic wr_clear(logic [2:0] mask);
    @(negedge clk); #1; csr_wr = 1; csr_wdata = mask;
    @(negedge clk); #1; csr_wr = 0; csr_wdata = 0;
    exp_stat = exp_stat & ~mask;
  endtask

  task automatic do_por(logic [4:0] straps);
    @(negedge clk); #1;
    por_n = 0;
    {s_dbg, s_host, s_boot, s_slave} = straps;
    #1;
    chk("R1 hard_drive in por", int'(hard_drive), 1);
    chk("R1 soft_drive in por", int'(soft_drive), 1);
    chk("R1 status in por", int'(rst_status), 1);
    chk("R1 modes in por", int'({m_dbg, m_host, m_boot, m_slave}), 0);
    repeat (3) @(negedge clk);
    #1; start_mon(); por_n = 1;
    repeat (HC + SC + 20) @(negedge clk);
    mon_en = 0;
    chk("R3 hard cycles after por", hc_cnt, HC + 1);
    chk("R3 soft cycles after por", sc_cnt, HC + SC + 1);
    chk("R2 captured modes", int'({m_dbg, m_host, m_boot, m_slave}), int'(straps));
    chk("R9 status after por", int'(rst_status), 1);
    {s_dbg, s_host, s_boot, s_slave} = ~straps;
    repeat (4) @(negedge clk);
    chk("R2 modes hold", int'({m_dbg, m_host, m_boot, m_slave}), int'(straps));
    exp_stat = 3'b001;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all-R actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    do_por(5'b10110);

    // R4: one-cycle glitch ignored, two-cycle low detected
    pulse(1, 0, 1);
    chk("R4 glitch hard count", hc_cnt, 0);
    chk("R4 glitch status", int'(rst_status), int'(exp_stat));
    pulse(1, 0, 2);
    chk("R4 min pulse hard count", hc_cnt, HC);
    chk("R5 soft follows hard", sc_cnt, HC + SC);
    chk("R5 hard without soft", bad_cnt, 0);
    exp_stat |= 3'b010;
    chk("R9 hard flag", int'(rst_status), int'(exp_stat));
    wr_clear(3'b111);
    chk("R9 w1c all", int'(rst_status), 0);

    // R4: exact rise edge
    @(negedge clk); #1; ext_hard = 1;
    repeat (3) @(negedge clk);
    chk("R4 not yet driving", int'(hard_drive), 0);
    @(negedge clk);
    chk("R4 drive on fourth edge", int'(hard_drive), 1);
    #1; ext_hard = 0;
    repeat (HC + SC + 20) @(negedge clk);
    exp_stat = 3'b010;
    wr_clear(3'b111);

    // R6 soft only
    pulse(0, 1, 3);
    chk("R6 soft no hard", hc_cnt, 0);
    chk("R6 soft length", sc_cnt, SC);
    chk("R9 soft flag", int'(rst_status), 4);
    wr_clear(3'b111);

    // R8 tie
    pulse(1, 1, 3);
    chk("R8 tie hard count", hc_cnt, HC);
    chk("R8 tie flags", int'(rst_status), 2);
    wr_clear(3'b111);

    // R7 hard request during own soft drive and release wait
    @(negedge clk); #1; start_mon(); ext_soft = 1;
    repeat (3) @(negedge clk); #1; ext_soft = 0;
    repeat (3) @(negedge clk); #1; ext_hard = 1;
    repeat (4) @(negedge clk); #1; ext_hard = 0;
    repeat (HC + SC + 20) @(negedge clk);
    mon_en = 0;
    chk("R7 busy hard ignored", hc_cnt, 0);
    chk("R7 busy soft length", sc_cnt, SC);
    chk("R7 busy flags", int'(rst_status), 4);
    wr_clear(3'b111);

    // R7 external pull outlasting own drive
    pulse(0, 1, SC + 12);
    chk("R7 long pull single sequence", sc_cnt, SC);
    wr_clear(3'b111);

    // R9 set beats clear in detection cycle
    @(negedge clk); #1; ext_hard = 1;
    repeat (3) @(negedge clk); #1; csr_wr = 1; csr_wdata = 3'b111;
    @(negedge clk); #1; csr_wr = 0; csr_wdata = 0; ext_hard = 0;
    chk("R9 set wins over clear", int'(rst_status), 2);
    repeat (HC + SC + 20) @(negedge clk);
    exp_stat = 3'b010;

    do_por(5'b01011);

    // random mix
    for (int i = 0; i < 30; i++) begin
      bit h = 1'($urandom % 2);
      bit s = 1'($urandom % 2);
      int len = 1 + int'($urandom % 6);
      logic [2:0] mask = 3'($urandom % 8);
      pulse(h, s, len);
      exp_stat |= exp_set(h, s, len);
      chk(h ? "R5 rand hard count" : "R4 rand hard count", hc_cnt, exp_hard(h, len));
      chk((h && s) ? "R8 rand soft count" : "R6 rand soft count", sc_cnt, exp_soft(h, s, len));
      chk("R9 rand status", int'(rst_status), int'(exp_stat));
      wr_clear(mask);
      chk("R9 rand clear", int'(rst_status), int'(exp_stat));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule